// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the test-port front end of a device: a standard 16-state test access port state machine clocked by `tck`. It holds an 18-bit instruction register, a 32-bit identification register and a single-stage bypass register. The instruction set is sparse and mostly made of ones. The loaded instruction is decoded into a register select and mode controls for an external boundary chain. That chain is not part of this block: it receives capture, shift and update strobes from here and returns its serial output on `bsr_so`.

All capture, shift and update actions happen on the rising edge of `tck`. The serial output `tdo` and its enable `tdo_oe` are re-registered on the falling edge. `trst` is a synchronous, active-high reset sampled on the rising edge of `tck`.

Top module: `jtag_tap_ctrl`

## Requirements
- R1: With `trst` high at a rising edge, the controller enters Test-Logic-Reset and the active instruction becomes IDCODE. `tdo_oe` is low from the following falling edge onward.
- R2: Five consecutive rising edges with `tms` high bring the controller to Test-Logic-Reset from any state, and IDCODE becomes the active instruction.
- R3: At Capture-IR the instruction shift register loads 18'h00001 (two low bits 01, upper bits zero). In Shift-IR it is shifted out on `tdo` least significant bit first.
- R4: Under IDCODE, Capture-DR loads the 32-bit identification word 32'h0064E067, shifted out LSB first. Its fields are: bit 0 fixed at 1, manufacturer code 0x033 in bits 11:1, part number 0x064E in bits 27:12, and version 0 in bits 31:28.
- R5: Under a bypass-type instruction, the 1-bit bypass stage captures 0 at Capture-DR and delays `tdi` by exactly one shift.
- R6: Opcodes (18 bits) are as follows: IDCODE 0x3FFFE, BYPASS 0x3FFFF, EXTEST 0x3FFE8, SAMPLE/PRELOAD 0x3FFF8, HIGHZ 0x3FFCF and CLAMP 0x3FFEF. Any other value acts as BYPASS. A new instruction takes effect at Update-IR.
- R7: Under EXTEST or SAMPLE/PRELOAD, `bsr_sel` is high and in Shift-DR `tdo` follows `bsr_so`. Under all other instructions `bsr_sel` is low.
- R8: `pins_from_bsr` is high only for EXTEST and CLAMP. `pins_hiz` is high only for HIGHZ. HIGHZ and CLAMP shift through the bypass stage.
- R9: `tdo_oe` is high only in Shift-IR and Shift-DR. `tdo` and `tdo_oe` change only on the falling edge of `tck`.
- R10: `bsr_capture`, `bsr_shift` and `bsr_update` are high only in Capture-DR, Shift-DR and Update-DR respectively, and only while `bsr_sel` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst | input | 1 | Synchronous active-high test reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_oe | output | 1 | Output enable for tdo |
| bsr_sel | output | 1 | Boundary chain is the selected data register |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| pins_from_bsr | output | 1 | Pins driven from boundary update stages |
| pins_hiz | output | 1 | All test-controlled outputs floated |

## Verification
A wrong state-machine state shows at the ports within one falling edge. `tdo_oe` opens or closes in the wrong cycle, or a boundary strobe fires where it should not. A corrupted instruction register or a wrong decode shows as soon as the next data register scan. The first `tdo` bit after Capture-DR is 1 for the identification word, 0 for bypass, and `bsr_so` for the boundary path, so the selected register is exposed after a single bit. A wrong shift direction or length in any register shows as a displaced or missing bit in the word read out, at the latest by the last bit of that scan.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

  typedef enum logic [3:0] {
    TS_RESET  = 4'h0,
    TS_IDLE   = 4'h1,
    TS_SEL_DR = 4'h2,
    TS_CAP_DR = 4'h3,
    TS_SH_DR  = 4'h4,
    TS_EX1_DR = 4'h5,
    TS_PAU_DR = 4'h6,
    TS_EX2_DR = 4'h7,
    TS_UPD_DR = 4'h8,
    TS_SEL_IR = 4'h9,
    TS_CAP_IR = 4'hA,
    TS_SH_IR  = 4'hB,
    TS_EX1_IR = 4'hC,
    TS_PAU_IR = 4'hD,
    TS_EX2_IR = 4'hE,
    TS_UPD_IR = 4'hF
  } tap_state_e;

  typedef enum logic [2:0] {
    IC_BYPASS = 3'd0,
    IC_IDCODE = 3'd1,
    IC_EXTEST = 3'd2,
    IC_SAMPLE = 3'd3,
    IC_HIGHZ  = 3'd4,
    IC_CLAMP  = 3'd5
  } instr_cls_e;

  function automatic tap_state_e tap_step(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
      TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
      TS_CAP_DR: n = m ? TS_EX1_DR : TS_SH_DR;
      TS_SH_DR:  n = m ? TS_EX1_DR : TS_SH_DR;
      TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
      TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
      TS_EX2_DR: n = m ? TS_UPD_DR : TS_SH_DR;
      TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
      TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
      TS_CAP_IR: n = m ? TS_EX1_IR : TS_SH_IR;
      TS_SH_IR:  n = m ? TS_EX1_IR : TS_SH_IR;
      TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
      TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
      TS_EX2_IR: n = m ? TS_UPD_IR : TS_SH_IR;
      TS_UPD_IR: n = m ? TS_SEL_DR : TS_IDLE;
      default:   n = TS_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/jtag_tap_fsm.sv
module jtag_tap_fsm
  import jtag_tap_pkg::*;
#(
  parameter int RESET_RUN = 5
) (
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  localparam int RUN_W = $clog2(RESET_RUN + 1);

  always_ff @(posedge tck) begin
    if (rst) state <= TS_RESET;
    else     state <= tap_step(state, tms);
  end

  // Run of consecutive tms-high edges since reset, saturating.
  logic [RUN_W-1:0] hi_run;
  always_ff @(posedge tck) begin
    if (rst)                                 hi_run <= '0;
    else if (!tms)                           hi_run <= '0;
    else if (hi_run != RUN_W'(RESET_RUN))    hi_run <= hi_run + 1'b1;
  end

  a_r2_five_high_resets: assert property (@(posedge tck) disable iff (rst)
    (hi_run == RUN_W'(RESET_RUN)) |-> (state == TS_RESET));

  logic rst_d;
  always_ff @(posedge tck) rst_d <= rst;

  always @(posedge tck) begin
    if (rst_d === 1'b1) begin
      a_r1_reset_enters_tlr: assert (state == TS_RESET);
    end
  end

endmodule

// File: rtl/jtag_tap_ir.sv
module jtag_tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W      = 18,
  parameter logic [IR_W-1:0] OP_IDCODE = 18'h3FFFE,
  parameter logic [IR_W-1:0] OP_BYPASS = 18'h3FFFF,
  parameter logic [IR_W-1:0] OP_EXTEST = 18'h3FFE8,
  parameter logic [IR_W-1:0] OP_SAMPLE = 18'h3FFF8,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 18'h3FFCF,
  parameter logic [IR_W-1:0] OP_CLAMP  = 18'h3FFEF
) (
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output logic       ir_lsb,
  output instr_cls_e cls
);

  localparam logic [IR_W-1:0] CAPTURE_VAL = {{(IR_W-2){1'b0}}, 2'b01};

  logic [IR_W-1:0] ir_sr;
  logic [IR_W-1:0] ir_act;

  always_ff @(posedge tck) begin
    if (rst || state == TS_RESET) begin
      ir_act <= OP_IDCODE;
    end else if (state == TS_UPD_IR) begin
      ir_act <= ir_sr;
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sr <= CAPTURE_VAL;
    end else if (state == TS_CAP_IR) begin
      ir_sr <= CAPTURE_VAL;
    end else if (state == TS_SH_IR) begin
      ir_sr <= {tdi, ir_sr[IR_W-1:1]};
    end
  end

  assign ir_lsb = ir_sr[0];

  always_comb begin
    if      (ir_act == OP_IDCODE) cls = IC_IDCODE;
    else if (ir_act == OP_EXTEST) cls = IC_EXTEST;
    else if (ir_act == OP_SAMPLE) cls = IC_SAMPLE;
    else if (ir_act == OP_HIGHZ)  cls = IC_HIGHZ;
    else if (ir_act == OP_CLAMP)  cls = IC_CLAMP;
    else if (ir_act == OP_BYPASS) cls = IC_BYPASS;
    else                          cls = IC_BYPASS;
  end

  a_r3_capture_pattern: assert property (@(posedge tck) disable iff (rst)
    (state == TS_CAP_IR) |=> (ir_sr == CAPTURE_VAL));

  a_r2_tlr_loads_idcode: assert property (@(posedge tck) disable iff (rst)
    (state == TS_RESET) |=> (cls == IC_IDCODE));

  a_r6_instr_held_outside_update: assert property (@(posedge tck) disable iff (rst)
    (state != TS_UPD_IR && state != TS_RESET) |=> $stable(ir_act));

endmodule

// File: rtl/jtag_tap_dr.sv
module jtag_tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int              ID_W   = 32,
  parameter logic [ID_W-1:0] ID_VAL = 32'h0064E067
) (
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       use_id,
  input  logic       use_byp,
  output logic       id_lsb,
  output logic       byp_bit
);

  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck) begin
    if (rst) begin
      id_sr <= ID_VAL;
    end else if (use_id && state == TS_CAP_DR) begin
      id_sr <= ID_VAL;
    end else if (use_id && state == TS_SH_DR) begin
      id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
    end else if (use_byp && state == TS_CAP_DR) begin
      byp_q <= 1'b0;
    end else if (use_byp && state == TS_SH_DR) begin
      byp_q <= tdi;
    end
  end

  assign id_lsb  = id_sr[0];
  assign byp_bit = byp_q;

  a_r4_id_capture: assert property (@(posedge tck) disable iff (rst)
    (use_id && state == TS_CAP_DR) |=> (id_sr == ID_VAL));

  a_r5_bypass_capture_zero: assert property (@(posedge tck) disable iff (rst)
    (use_byp && state == TS_CAP_DR) |=> (byp_q == 1'b0));

  a_r5_bypass_one_stage: assert property (@(posedge tck) disable iff (rst)
    (use_byp && state == TS_SH_DR) |=> (byp_q == $past(tdi)));

endmodule

// File: rtl/jtag_tap_ctrl.sv
module jtag_tap_ctrl
  import jtag_tap_pkg::*;
#(
  parameter int              IR_W      = 18,
  parameter int              ID_W      = 32,
  parameter int              RESET_RUN = 5,
  parameter logic [ID_W-1:0] ID_VAL    = 32'h0064E067,
  parameter logic [IR_W-1:0] OP_IDCODE = 18'h3FFFE,
  parameter logic [IR_W-1:0] OP_BYPASS = 18'h3FFFF,
  parameter logic [IR_W-1:0] OP_EXTEST = 18'h3FFE8,
  parameter logic [IR_W-1:0] OP_SAMPLE = 18'h3FFF8,
  parameter logic [IR_W-1:0] OP_HIGHZ  = 18'h3FFCF,
  parameter logic [IR_W-1:0] OP_CLAMP  = 18'h3FFEF
) (
  input  logic tck,
  input  logic trst,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bsr_sel,
  output logic bsr_capture,
  output logic bsr_shift,
  output logic bsr_update,
  output logic pins_from_bsr,
  output logic pins_hiz
);

  tap_state_e state;
  instr_cls_e cls;
  logic       ir_lsb, id_lsb, byp_bit;
  logic       use_id, use_byp, use_bsr;

  jtag_tap_fsm #(.RESET_RUN(RESET_RUN)) u_fsm (
    .tck   (tck),
    .rst   (trst),
    .tms   (tms),
    .state (state)
  );

  jtag_tap_ir #(
    .IR_W      (IR_W),
    .OP_IDCODE (OP_IDCODE),
    .OP_BYPASS (OP_BYPASS),
    .OP_EXTEST (OP_EXTEST),
    .OP_SAMPLE (OP_SAMPLE),
    .OP_HIGHZ  (OP_HIGHZ),
    .OP_CLAMP  (OP_CLAMP)
  ) u_ir (
    .tck    (tck),
    .rst    (trst),
    .state  (state),
    .tdi    (tdi),
    .ir_lsb (ir_lsb),
    .cls    (cls)
  );

  assign use_id  = (cls == IC_IDCODE);
  assign use_bsr = (cls == IC_EXTEST) || (cls == IC_SAMPLE);
  assign use_byp = !use_id && !use_bsr;

  jtag_tap_dr #(.ID_W(ID_W), .ID_VAL(ID_VAL)) u_dr (
    .tck     (tck),
    .rst     (trst),
    .state   (state),
    .tdi     (tdi),
    .use_id  (use_id),
    .use_byp (use_byp),
    .id_lsb  (id_lsb),
    .byp_bit (byp_bit)
  );

  logic serial_out;
  always_comb begin
    if (state == TS_SH_IR)  serial_out = ir_lsb;
    else if (use_id)        serial_out = id_lsb;
    else if (use_bsr)       serial_out = bsr_so;
    else                    serial_out = byp_bit;
  end

  always_ff @(negedge tck) begin
    if (trst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= serial_out;
      tdo_oe <= (state == TS_SH_IR) || (state == TS_SH_DR);
    end
  end

  assign bsr_sel       = use_bsr;
  assign bsr_capture   = use_bsr && (state == TS_CAP_DR);
  assign bsr_shift     = use_bsr && (state == TS_SH_DR);
  assign bsr_update    = use_bsr && (state == TS_UPD_DR);
  assign pins_from_bsr = (cls == IC_EXTEST) || (cls == IC_CLAMP);
  assign pins_hiz      = (cls == IC_HIGHZ);

  a_r9_oe_only_in_shift: assert property (@(posedge tck) disable iff (trst)
    tdo_oe |-> (state == TS_SH_IR || state == TS_SH_DR));

  a_r6_one_data_path: assert property (@(posedge tck) disable iff (trst)
    $onehot({use_id, use_byp, use_bsr}));

  a_r10_strobes_exclusive: assert property (@(posedge tck) disable iff (trst)
    $onehot0({bsr_capture, bsr_shift, bsr_update}));

  a_r8_modes_exclusive: assert property (@(posedge tck) disable iff (trst)
    !(pins_hiz && pins_from_bsr));

endmodule

// File: tb/jtag_tap_ctrl_tb.sv
module jtag_tap_ctrl_tb;

  localparam int TCK_PERIOD = 100;
  localparam logic [31:0] ID_EXP = {4'h0, 16'h064E, 11'h033, 1'b1};
  localparam logic [17:0] OP_IDCODE = 18'h3FFFE;
  localparam logic [17:0] OP_BYPASS = 18'h3FFFF;
  localparam logic [17:0] OP_EXTEST = 18'h3FFE8;
  localparam logic [17:0] OP_SAMPLE = 18'h3FFF8;
  localparam logic [17:0] OP_HIGHZ  = 18'h3FFCF;
  localparam logic [17:0] OP_CLAMP  = 18'h3FFEF;

  logic tck = 1'b0;
  logic trst, tms, tdi, bsr_so;
  logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update;
  logic pins_from_bsr, pins_hiz;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  jtag_tap_ctrl u_dut (
    .tck(tck), .trst(trst), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsr_sel(bsr_sel),
    .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .pins_from_bsr(pins_from_bsr), .pins_hiz(pins_hiz)
  );

  always #(TCK_PERIOD/2) tck = ~tck;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One TCK cycle; outputs sampled just after the falling edge.
  task automatic tick(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    @(negedge tck);
    #1;
  endtask

  task automatic shift_bits(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
  endtask

  task automatic load_ir(input logic [17:0] op, output logic [63:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(18, {46'd0, op}, cap);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic read_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    tick(1, 0); tick(0, 0); tick(0, 0);
    shift_bits(n, din, dout);
    tick(1, 0); tick(0, 0);
  endtask

  function automatic logic [63:0] bypass_model(input logic [63:0] din, input int n);
    logic [63:0] r;
    r = '0;
    for (int i = 1; i < n; i++) r[i] = din[i-1];
    return r;
  endfunction

  function automatic bit known_op(input logic [17:0] op);
    return op == OP_IDCODE || op == OP_BYPASS || op == OP_EXTEST ||
           op == OP_SAMPLE || op == OP_HIGHZ  || op == OP_CLAMP;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [63:0] d;
    logic [63:0] din;
    logic [17:0] op;
    void'($urandom(32'd20240611));
    trst = 1'b1; tms = 1'b0; tdi = 1'b0; bsr_so = 1'b0;
    tick(0, 0); tick(0, 0);
    // R1: reset state
    chk("R1 tdo_oe after reset", 64'(tdo_oe), 64'd0);
    chk("R1 no boundary select", 64'(bsr_sel), 64'd0);
    trst = 1'b0;
    tick(0, 0);
    read_dr(32, 64'hA5A5_5A5A, d);
    chk("R1 IDCODE active after reset", d, 64'(ID_EXP));
    chk("R4 identification word", d[31:0], 64'h0064E067);

    // R3: capture value of instruction register
    load_ir(OP_BYPASS, d);
    chk("R3 capture-IR pattern", d, 64'h00001);

    // R5 + R9: bypass with falling-edge timing check
    tick(1, 0); tick(0, 0); tick(0, 0);
    chk("R9 tdo_oe in Shift-DR", 64'(tdo_oe), 64'd1);
    chk("R5 bypass captures zero", 64'(tdo), 64'd0);
    tms = 0; tdi = 1;
    @(posedge tck); #1;
    chk("R9 tdo holds until falling edge", 64'(tdo), 64'd0);
    @(negedge tck); #1;
    chk("R9 tdo updates on falling edge", 64'(tdo), 64'd1);
    tick(1, 0);
    chk("R9 tdo_oe off in Exit1-DR", 64'(tdo_oe), 64'd0);
    tick(1, 0); tick(0, 0);

    for (int k = 0; k < 4; k++) begin
      din = {32'd0, $urandom()};
      read_dr(20, din, d);
      chk("R5 bypass delays by one", d, bypass_model(din, 20));
    end

    // R6: unknown opcodes act as BYPASS
    for (int k = 0; k < 6; k++) begin
      op = 18'($urandom());
      if (known_op(op)) op = 18'h00000;
      load_ir(op, d);
      read_dr(2, 64'd0, d);
      chk("R6 unknown opcode as bypass", d, 64'd0);
      chk("R7 unknown opcode not boundary", 64'(bsr_sel), 64'd0);
    end
    load_ir(OP_IDCODE, d);
    read_dr(32, 64'd0, d);
    chk("R6 IDCODE opcode selects id", d, 64'(ID_EXP));

    // R7 + R10: EXTEST
    load_ir(OP_EXTEST, d);
    chk("R7 EXTEST bsr_sel", 64'(bsr_sel), 64'd1);
    chk("R8 EXTEST drives from boundary", 64'(pins_from_bsr), 64'd1);
    chk("R8 EXTEST not floated", 64'(pins_hiz), 64'd0);
    tick(1, 0); tick(0, 0);
    chk("R10 capture strobe", {bsr_capture, bsr_shift, bsr_update}, 64'b100);
    bsr_so = 1'b1;
    tick(0, 0);
    chk("R10 shift strobe", {bsr_capture, bsr_shift, bsr_update}, 64'b010);
    chk("R7 tdo follows boundary 1", 64'(tdo), 64'd1);
    bsr_so = 1'b0;
    tick(0, 0);
    chk("R7 tdo follows boundary 0", 64'(tdo), 64'd0);
    tick(1, 0);
    chk("R10 no strobe in Exit1", {bsr_capture, bsr_shift, bsr_update}, 64'b000);
    tick(1, 0);
    chk("R10 update strobe", {bsr_capture, bsr_shift, bsr_update}, 64'b001);
    tick(0, 0);

    // SAMPLE/PRELOAD
    load_ir(OP_SAMPLE, d);
    chk("R7 SAMPLE bsr_sel", 64'(bsr_sel), 64'd1);
    chk("R8 SAMPLE leaves pins", {pins_from_bsr, pins_hiz}, 64'b00);

    // HIGHZ and CLAMP use bypass
    load_ir(OP_HIGHZ, d);
    chk("R8 HIGHZ modes", {bsr_sel, pins_from_bsr, pins_hiz}, 64'b001);
    read_dr(3, 64'b011, d);
    chk("R8 HIGHZ bypass path", d, 64'b110);
    load_ir(OP_CLAMP, d);
    chk("R8 CLAMP modes", {bsr_sel, pins_from_bsr, pins_hiz}, 64'b010);
    read_dr(3, 64'b001, d);
    chk("R8 CLAMP bypass path", d, 64'b010);
    tick(1, 0); tick(0, 0);
    chk("R10 no strobe without boundary", 64'(bsr_capture), 64'd0);
    tick(1, 0); tick(1, 0); tick(0, 0);

    // R2: random walks then five tms-high
    for (int k = 0; k < 5; k++) begin
      load_ir(OP_BYPASS, d);
      for (int j = 0; j < 25; j++) tick(1'($urandom()), 1'($urandom()));
      for (int j = 0; j < 5; j++) tick(1, 0);
      chk("R2 tdo_oe low in reset", 64'(tdo_oe), 64'd0);
      tick(0, 0);
      read_dr(32, 64'd0, d);
      chk("R2 IDCODE after five ones", d, 64'(ID_EXP));
    end

    // R1: trst in the middle of Shift-DR
    load_ir(OP_BYPASS, d);
    tick(1, 0); tick(0, 0); tick(0, 0);
    trst = 1'b1;
    tick(0, 0);
    chk("R1 trst closes tdo_oe", 64'(tdo_oe), 64'd0);
    trst = 1'b0;
    tick(0, 0);
    read_dr(32, 64'd0, d);
    chk("R1 trst restores IDCODE", d, 64'(ID_EXP));

    finish_run();
  end

endmodule